// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns digitised supply-supervision inputs into a system reset and a separate flag for a second supply rail. A primary-supply-good flag, a second-rail-good flag, an active-low push-button input and a two-bit interval-select code come in. A pair of complementary reset outputs and a second-rail fail flag go out. Supply states arrive as synchronous flags, so comparators, thresholds and pin drivers sit outside the block.

Reset is asserted while the chip-level power-on reset is low. It stays asserted until the primary supply has been good for a whole release interval. A brownout asserts reset again in the same cycle. Pressing the button holds reset for as long as the button is down, and reset then stays asserted for one more release interval after the button is let go. A single countdown timer serves every reset cause, and any new cause restarts it from zero. The second-rail flag uses a timer of its own with the same selectable interval.

Top module: `supv_reset_seq`

## Requirements
- R1: While `por_n` is low, `sys_rst` is 1, `sys_rst_n` is 0 and `aux_fail` is 1, whatever the other inputs are.
- R2: After `vmain_ok` has been 1 for exactly L consecutive rising edges with no other cause present, `sys_rst` falls. The value of `tsel` selects L: 0 gives INT0, 1 gives INT1, 2 gives INT2 and 3 gives INT3 (defaults 16, 24, 40, 64). After L-1 edges `sys_rst` is still 1.
- R3: When `vmain_ok` goes low, `sys_rst` is 1 in that same cycle, before any clock edge, and it stays 1 while `vmain_ok` is low.
- R4: A low level on `mr_btn_n` is taken as a press once it has passed two synchroniser flops and DEB_CYCLES matching debounce samples, which is 2+DEB_CYCLES edges after the change. `sys_rst` stays 1 for as long as the press lasts. After the button is released, the release goes through the same 2+DEB_CYCLES delay, and `sys_rst` then stays 1 for a further L edges.
- R5: A low pulse on `mr_btn_n` that lasts fewer than DEB_CYCLES cycles is ignored, and `sys_rst` stays 0.
- R6: A reset cause that appears during a countdown restarts the countdown from zero. After a one-cycle dip in `vmain_ok`, a full L edges must pass again before release.
- R7: When `vaux_ok` goes low, `aux_fail` is 1 in the same cycle. Once `vaux_ok` is back to 1, `aux_fail` falls after L edges and not after L-1. `vaux_ok` has no effect on `sys_rst`.
- R8: `sys_rst_n` is always the inverse of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vmain_ok | input | 1 | Primary supply above trip level, synchronous flag |
| vaux_ok | input | 1 | Second monitored rail above trip level, synchronous flag |
| mr_btn_n | input | 1 | Manual reset button, low while pressed, asynchronous |
| tsel | input | 2 | Release interval select code |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| aux_fail | output | 1 | Second-rail fail flag, active high |

## Verification
The properties assume that `vmain_ok` and `vaux_ok` only change away from the clock edge, as any synchronous flag does, and that `tsel` stays fixed while a countdown that is being judged is running. The release-time properties compare against the shortest interval, so they remain true for any select code. The bench sets `tsel` before it raises the supply flag and drives every input on the falling edge. Button pulses are either clearly shorter than the debounce window or held far past it, so no result depends on an edge landing exactly at the boundary.

// File: rtl/supv_pkg.sv
`timescale 1ns/1ps
package supv_pkg;
   typedef logic [1:0] tsel_t;

   localparam int unsigned NUM_TIMERS = 2;
   localparam int unsigned TMR_MAIN   = 0;
   localparam int unsigned TMR_AUX    = 1;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int unsigned min4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b < m) m = b;
      if (c < m) m = c;
      if (d < m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/supv_btn_filter.sv
`timescale 1ns/1ps
module supv_btn_filter #(
   parameter int unsigned DEB_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n_async,
   output logic pressed
);
   localparam int unsigned DW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

   logic s1_q, s2_q, level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b1;
         s2_q <= 1'b1;
      end else begin
         s1_q <= btn_n_async;
         s2_q <= s1_q;
      end
   end

   generate
      if (DEB_CYCLES == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) level_q <= 1'b1;
            else        level_q <= s2_q;
         end
      end else begin : g_count
         logic [DW-1:0] run_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level_q <= 1'b1;
               run_q   <= '0;
            end else if (s2_q == level_q) begin
               run_q <= '0;
            end else if (run_q == DW'(DEB_CYCLES - 1)) begin
               level_q <= s2_q;
               run_q   <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

   assign pressed = ~level_q;
endmodule

// File: rtl/supv_hold_timer.sv
`timescale 1ns/1ps
module supv_hold_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cause,
   input  logic [CNT_W-1:0] limit,
   output logic             hold
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   next_cnt;

   assign next_cnt = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold  <= 1'b1;
         cnt_q <= '0;
      end else if (cause) begin
         hold  <= 1'b1;
         cnt_q <= '0;
      end else if (hold) begin
         if (next_cnt >= {1'b0, limit}) begin
            hold  <= 1'b0;
            cnt_q <= '0;
         end else begin
            cnt_q <= next_cnt[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/supv_reset_seq.sv
`timescale 1ns/1ps
module supv_reset_seq
   import supv_pkg::*;
#(
   parameter int unsigned DEB_CYCLES = 4,
   parameter int unsigned INT0       = 16,
   parameter int unsigned INT1       = 24,
   parameter int unsigned INT2       = 40,
   parameter int unsigned INT3       = 64
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       vmain_ok,
   input  logic       vaux_ok,
   input  logic       mr_btn_n,
   input  logic [1:0] tsel,
   output logic       sys_rst,
   output logic       sys_rst_n,
   output logic       aux_fail
);
   localparam int unsigned INT_MAX = max4(INT0, INT1, INT2, INT3);
   localparam int unsigned INT_MIN = min4(INT0, INT1, INT2, INT3);
   localparam int unsigned CNT_W   = $clog2(INT_MAX + 1);

   generate
      if (INT_MIN < 2) begin : g_bad_interval
         $error("supv_reset_seq: every release interval must be at least 2 cycles");
      end
      if (DEB_CYCLES < 1) begin : g_bad_debounce
         $error("supv_reset_seq: DEB_CYCLES must be at least 1");
      end
   endgenerate

   logic             mr_pressed;
   logic [CNT_W-1:0] limit;
   logic [NUM_TIMERS-1:0] cause;
   logic [NUM_TIMERS-1:0] hold;

   supv_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
      .clk        (clk),
      .rst_n      (por_n),
      .btn_n_async(mr_btn_n),
      .pressed    (mr_pressed)
   );

   always_comb begin
      unique case (tsel_t'(tsel))
         2'd0:    limit = CNT_W'(INT0);
         2'd1:    limit = CNT_W'(INT1);
         2'd2:    limit = CNT_W'(INT2);
         default: limit = CNT_W'(INT3);
      endcase
   end

   assign cause[TMR_MAIN] = ~vmain_ok | mr_pressed;
   assign cause[TMR_AUX]  = ~vaux_ok;

   generate
      for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
         supv_hold_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk  (clk),
            .rst_n(por_n),
            .cause(cause[i]),
            .limit(limit),
            .hold (hold[i])
         );
      end
   endgenerate

   assign sys_rst   = cause[TMR_MAIN] | hold[TMR_MAIN];
   assign sys_rst_n = ~sys_rst;
   assign aux_fail  = cause[TMR_AUX] | hold[TMR_AUX];
endmodule

// File: rtl/supv_reset_seq_chk.sv
`timescale 1ns/1ps
module supv_reset_seq_chk
   import supv_pkg::*;
#(
   parameter int unsigned DEB_CYCLES = 4,
   parameter int unsigned INT0       = 16,
   parameter int unsigned INT1       = 24,
   parameter int unsigned INT2       = 40,
   parameter int unsigned INT3       = 64
) (
   input logic       clk,
   input logic       por_n,
   input logic       vmain_ok,
   input logic       vaux_ok,
   input logic       mr_btn_n,
   input logic [1:0] tsel,
   input logic       sys_rst,
   input logic       sys_rst_n,
   input logic       aux_fail
);
   localparam int unsigned INT_MIN = min4(INT0, INT1, INT2, INT3);
   localparam logic [15:0] SAT     = 16'hFFFF;

   logic [15:0] main_run, aux_run, btn_low_run;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         main_run    <= '0;
         aux_run     <= '0;
         btn_low_run <= '0;
      end else begin
         main_run    <= !vmain_ok ? '0 : (main_run == SAT ? SAT : main_run + 1'b1);
         aux_run     <= !vaux_ok  ? '0 : (aux_run  == SAT ? SAT : aux_run + 1'b1);
         btn_low_run <= mr_btn_n  ? '0 : (btn_low_run == SAT ? SAT : btn_low_run + 1'b1);
      end
   end

   p_release_after_interval_r2: assert property (@(posedge clk) disable iff (!por_n)
      $fell(sys_rst) |-> main_run >= 16'(INT_MIN));

   p_brownout_holds_r3: assert property (@(posedge clk) disable iff (!por_n)
      !vmain_ok |=> sys_rst);

   p_button_holds_r4: assert property (@(posedge clk) disable iff (!por_n)
      (btn_low_run >= 16'(DEB_CYCLES + 2)) |-> sys_rst);

   p_aux_asserts_r7: assert property (@(posedge clk) disable iff (!por_n)
      !vaux_ok |=> aux_fail);

   p_aux_release_after_interval_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(aux_fail) |-> aux_run >= 16'(INT_MIN));

   p_polarity_r8: assert property (@(posedge clk) disable iff (!por_n)
      sys_rst_n == !sys_rst);
endmodule

bind supv_reset_seq supv_reset_seq_chk #(
   .DEB_CYCLES(DEB_CYCLES), .INT0(INT0), .INT1(INT1), .INT2(INT2), .INT3(INT3)
) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .vmain_ok (vmain_ok),
   .vaux_ok  (vaux_ok),
   .mr_btn_n (mr_btn_n),
   .tsel     (tsel),
   .sys_rst  (sys_rst),
   .sys_rst_n(sys_rst_n),
   .aux_fail (aux_fail)
);

// File: tb/sim_supv_reset_seq.sv
`timescale 1ns/1ps
module sim_supv_reset_seq;
   localparam int DEB = 4;
   localparam int I0 = 16, I1 = 24, I2 = 40, I3 = 64;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic vmain_ok = 1'b1, vaux_ok = 1'b1, mr_btn_n = 1'b1;
   logic [1:0] tsel = 2'd0;
   logic sys_rst, sys_rst_n, aux_fail;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   supv_reset_seq #(.DEB_CYCLES(DEB), .INT0(I0), .INT1(I1), .INT2(I2), .INT3(I3)) u0 (
      .clk(clk), .por_n(por_n), .vmain_ok(vmain_ok), .vaux_ok(vaux_ok),
      .mr_btn_n(mr_btn_n), .tsel(tsel),
      .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .aux_fail(aux_fail)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_rst(input string req, input logic exp);
      chk(req, "sys_rst", sys_rst, exp);
      chk("R8", "sys_rst_n", sys_rst_n, ~exp);
   endtask

   task automatic negs(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_power_up;
      por_n = 1'b0; vmain_ok = 1'b1; vaux_ok = 1'b1; mr_btn_n = 1'b1; tsel = 2'd0;
      negs(3);
      chk_rst("R1", 1'b1);
      chk("R1", "aux_fail", aux_fail, 1'b1);
      por_n = 1'b1;
      negs(I0 - 1);
      chk_rst("R2", 1'b1);
      chk("R7", "aux_fail", aux_fail, 1'b1);
      negs(1);
      chk_rst("R2", 1'b0);
      chk("R7", "aux_fail", aux_fail, 1'b0);
   endtask

   task automatic t_interval(input logic [1:0] sel, input int len);
      vmain_ok = 1'b0;
      #1;
      chk_rst("R3", 1'b1);
      negs(3);
      chk_rst("R3", 1'b1);
      tsel = sel;
      vmain_ok = 1'b1;
      negs(len - 1);
      chk_rst("R2", 1'b1);
      negs(1);
      chk_rst("R2", 1'b0);
   endtask

   task automatic t_restart;
      tsel = 2'd0;
      vmain_ok = 1'b0;
      negs(2);
      vmain_ok = 1'b1;
      negs(10);
      chk_rst("R6", 1'b1);
      vmain_ok = 1'b0;
      negs(1);
      vmain_ok = 1'b1;
      negs(I0 - 1);
      chk_rst("R6", 1'b1);
      negs(1);
      chk_rst("R6", 1'b0);
   endtask

   task automatic t_manual;
      tsel = 2'd0;
      mr_btn_n = 1'b0;
      negs(1 + DEB);
      chk_rst("R4", 1'b0);
      negs(1);
      chk_rst("R4", 1'b1);
      negs(30);
      chk_rst("R4", 1'b1);
      mr_btn_n = 1'b1;
      negs(2 + DEB + I0 - 1);
      chk_rst("R4", 1'b1);
      negs(1);
      chk_rst("R4", 1'b0);
   endtask

   task automatic t_glitch;
      logic seen;
      seen = 1'b0;
      mr_btn_n = 1'b0;
      for (int i = 0; i < DEB - 1; i++) begin
         @(negedge clk);
         seen |= sys_rst;
      end
      mr_btn_n = 1'b1;
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         seen |= sys_rst;
      end
      chk("R5", "sys_rst seen during short press", seen, 1'b0);
   endtask

   task automatic t_aux;
      tsel = 2'd1;
      vaux_ok = 1'b0;
      #1;
      chk("R7", "aux_fail", aux_fail, 1'b1);
      negs(5);
      chk("R7", "aux_fail", aux_fail, 1'b1);
      chk_rst("R7", 1'b0);
      vaux_ok = 1'b1;
      negs(I1 - 1);
      chk("R7", "aux_fail", aux_fail, 1'b1);
      negs(1);
      chk("R7", "aux_fail", aux_fail, 1'b0);
      chk_rst("R7", 1'b0);
   endtask

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_power_up();
      t_interval(2'd0, I0);
      t_interval(2'd1, I1);
      t_interval(2'd2, I2);
      t_interval(2'd3, I3);
      t_restart();
      t_manual();
      t_glitch();
      t_aux();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule